// File: doc/BRIEF.md
# Dock handshake flush coordinator

This block wraps the request/acknowledge handshakes of a functional unit that has several input docks and several output docks. Each input dock carries a data word plus one extra most-significant bit. When that bit is set, the token is a flush token rather than ordinary data. For every dock the wrapper derives an effective request, a flushing indication and full/empty status. It also hands the plain payload word, with the marker bit removed, to the unit.

The output side is simple. Once an offered output has been acknowledged, the wrapper withdraws the request by itself. The input side needs more care. Flush tokens may reach different inputs at different times, and they must be consumed as a group. Each cycle the wrapper sorts the inputs into one of three coordination modes: none flushing, some flushing, or all flushing. It then moves every input acknowledge according to that mode.

The unit's compute logic touches the handshakes in only two ways. A per-input drain strobe raises an input acknowledge. A per-output fill strobe raises an output request. Both take effect on the next clock edge and take priority over the wrapper's own moves.

Each input dock is a two-state machine: IN_ACKED (acknowledge high) and IN_OPEN (acknowledge low). Its transitions are:
- RELEASE: IN_ACKED to IN_OPEN, taken in NONE or SOME mode when the dock has no request.
- CONSUME: IN_OPEN to IN_ACKED, taken in SOME mode when the effective request is high.
- GANG: any state to IN_ACKED, taken in ALL mode.
- DRAIN: any state to IN_ACKED, taken on the drain strobe.

Each output dock is a two-state machine: OUT_IDLE (request low) and OUT_OFFER (request high). Its transitions are:
- FILL: any state to OUT_OFFER, taken on the fill strobe.
- RETIRE: OUT_OFFER to OUT_IDLE, taken when the acknowledge is seen.

Top module: `dock_flush_coord`

## Requirements
- R1: While reset is high, every input acknowledge is set to 1 and every output request to 0 at each clock edge.
- R2: Input dock i occupies bits [i*(W+1) +: W+1] of in_data, where W is WORD_W. Bit W of that slice is the flush marker and bits W-1:0 are the payload word, presented on in_word[i*W +: W]. The effective request is in_eff_req[i] = in_req[i] AND NOT marker.
- R3: in_flush[i] is high exactly when in_req[i] is high, the marker of input i is 1, and in_ack[i] is low.
- R4: An input is full when in_eff_req is high and in_ack is low. An input is empty when both are low. An output is full when out_req is high and out_ack is low. An output is empty when both are low.
- R5: An output whose out_req and out_ack are both high, with no fill, has out_req low after the next edge. Otherwise, without a fill, out_req holds.
- R6: A fill pulse on output j makes out_req[j] 1 after the next edge, whatever out_ack is.
- R7: When every input is flushing, every in_ack is 1 after the next edge.
- R8: When no input is flushing, an input with in_req low and in_ack high has in_ack 0 after the next edge. Every other input keeps its in_ack.
- R9: When some but not all inputs are flushing, an input with effective request low and in_ack high drops in_ack. An input with effective request high and in_ack low raises in_ack. All others hold.
- R10: A drain pulse on input i makes in_ack[i] 1 after the next edge, overriding R8 and R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_req | input | N_IN | Raw request per input dock |
| in_data | input | N_IN*(WORD_W+1) | Per-input word with flush marker on top |
| drain | input | N_IN | Unit strobe that raises an input acknowledge |
| in_ack | output | N_IN | Acknowledge per input dock |
| in_word | output | N_IN*WORD_W | Payload words with the marker removed |
| in_eff_req | output | N_IN | Request qualified by the absence of the marker |
| in_flush | output | N_IN | Input holds an unconsumed flush token |
| in_full | output | N_IN | Input full status |
| in_empty | output | N_IN | Input empty status |
| out_ack | input | N_OUT | Acknowledge per output dock from the consumer |
| fill | input | N_OUT | Unit strobe that raises an output request |
| out_req | output | N_OUT | Request per output dock |
| out_full | output | N_OUT | Output full status |
| out_empty | output | N_OUT | Output empty status |

## Verification
The properties assume that every input is at a known 0 or 1 at each rising edge, and that reset is high at the first edge. They do not assume a legal handshake order on the far side. A consumer may hold out_ack, and a producer may hold or drop in_req, in any cycle. The stimulus holds reset for two edges at the start and pulses it once mid-run. All other inputs are driven at the falling edge, in directed sequences that step through the NONE, SOME and ALL modes, and then in random phases. These phases bias request, marker, drain, fill and acknowledge densities so that each coordination mode occurs many times.

// File: rtl/dock_flush_pkg.sv
package dock_flush_pkg;

    // Coordination mode derived from the set of flushing inputs
    typedef enum logic [1:0] {
        MODE_NONE = 2'd0,
        MODE_SOME = 2'd1,
        MODE_ALL  = 2'd2
    } flush_mode_e;

    // Input dock state: acknowledge low (open) or high (acked)
    typedef enum logic {
        IN_OPEN  = 1'b0,
        IN_ACKED = 1'b1
    } in_state_e;

    // Output dock state: request low (idle) or high (offer)
    typedef enum logic {
        OUT_IDLE  = 1'b0,
        OUT_OFFER = 1'b1
    } out_state_e;

endpackage

// File: rtl/dock_flush_classify.sv
module dock_flush_classify
    import dock_flush_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int WORD_W = 8
) (
    input  logic [N_IN-1:0]            in_req,
    input  logic [N_IN*(WORD_W+1)-1:0] in_data,
    input  logic [N_IN-1:0]            in_ack,
    output logic [N_IN*WORD_W-1:0]     word,
    output logic [N_IN-1:0]            eff_req,
    output logic [N_IN-1:0]            flushing,
    output flush_mode_e                mode
);
    localparam int SLOT_W = WORD_W + 1;

    logic [N_IN-1:0] marker;

    for (genvar i = 0; i < N_IN; i++) begin : g_slot
        assign marker[i]                 = in_data[i*SLOT_W + WORD_W];
        assign word[i*WORD_W +: WORD_W]  = in_data[i*SLOT_W +: WORD_W];
        assign eff_req[i]                = in_req[i] & ~marker[i];
        assign flushing[i]               = in_req[i] & marker[i] & ~in_ack[i];
    end

    always_comb begin
        if (&flushing)
            mode = MODE_ALL;
        else if (flushing == '0)
            mode = MODE_NONE;
        else
            mode = MODE_SOME;
    end

endmodule

// File: rtl/dock_in_fsm.sv
module dock_in_fsm
    import dock_flush_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        raw_req,
    input  logic        eff_req,
    input  logic        drain,
    input  flush_mode_e mode,
    output logic        ack
);
    in_state_e cur, nxt;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= IN_ACKED;
        else
            cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (mode)
            MODE_ALL: begin
                nxt = IN_ACKED;                               // GANG
            end
            MODE_NONE: begin
                if (!raw_req && cur == IN_ACKED)
                    nxt = IN_OPEN;                            // RELEASE
            end
            MODE_SOME: begin
                if (!eff_req && cur == IN_ACKED)
                    nxt = IN_OPEN;                            // RELEASE
                else if (eff_req && cur == IN_OPEN)
                    nxt = IN_ACKED;                           // CONSUME
            end
            default: nxt = cur;
        endcase
        if (drain)
            nxt = IN_ACKED;                                   // DRAIN
    end

    assign ack = (cur == IN_ACKED);

endmodule

// File: rtl/dock_out_fsm.sv
module dock_out_fsm
    import dock_flush_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fill,
    input  logic ack,
    output logic req
);
    out_state_e cur, nxt;

    always_ff @(posedge clk) begin
        if (rst)
            cur <= OUT_IDLE;
        else
            cur <= nxt;
    end

    always_comb begin
        nxt = cur;
        unique case (cur)
            OUT_OFFER: if (ack) nxt = OUT_IDLE;               // RETIRE
            OUT_IDLE:  nxt = OUT_IDLE;
            default:   nxt = cur;
        endcase
        if (fill)
            nxt = OUT_OFFER;                                  // FILL
    end

    assign req = (cur == OUT_OFFER);

endmodule

// File: rtl/dock_flush_coord.sv
module dock_flush_coord
    import dock_flush_pkg::*;
#(
    parameter int N_IN   = 3,
    parameter int N_OUT  = 2,
    parameter int WORD_W = 8
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [N_IN-1:0]            in_req,
    input  logic [N_IN*(WORD_W+1)-1:0] in_data,
    input  logic [N_IN-1:0]            drain,
    output logic [N_IN-1:0]            in_ack,
    output logic [N_IN*WORD_W-1:0]     in_word,
    output logic [N_IN-1:0]            in_eff_req,
    output logic [N_IN-1:0]            in_flush,
    output logic [N_IN-1:0]            in_full,
    output logic [N_IN-1:0]            in_empty,
    input  logic [N_OUT-1:0]           out_ack,
    input  logic [N_OUT-1:0]           fill,
    output logic [N_OUT-1:0]           out_req,
    output logic [N_OUT-1:0]           out_full,
    output logic [N_OUT-1:0]           out_empty
);
    flush_mode_e mode;

    dock_flush_classify #(.N_IN(N_IN), .WORD_W(WORD_W)) u_classify (
        .in_req   (in_req),
        .in_data  (in_data),
        .in_ack   (in_ack),
        .word     (in_word),
        .eff_req  (in_eff_req),
        .flushing (in_flush),
        .mode     (mode)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        dock_in_fsm u_in (
            .clk     (clk),
            .rst     (rst),
            .raw_req (in_req[i]),
            .eff_req (in_eff_req[i]),
            .drain   (drain[i]),
            .mode    (mode),
            .ack     (in_ack[i])
        );
        assign in_full[i]  =  in_eff_req[i] & ~in_ack[i];
        assign in_empty[i] = ~in_eff_req[i] & ~in_ack[i];
    end

    for (genvar j = 0; j < N_OUT; j++) begin : g_out
        dock_out_fsm u_out (
            .clk  (clk),
            .rst  (rst),
            .fill (fill[j]),
            .ack  (out_ack[j]),
            .req  (out_req[j])
        );
        assign out_full[j]  =  out_req[j] & ~out_ack[j];
        assign out_empty[j] = ~out_req[j] & ~out_ack[j];
    end

endmodule

// File: rtl/dock_flush_coord_chk.sv
module dock_flush_coord_chk #(
    parameter int N_IN  = 3,
    parameter int N_OUT = 2
) (
    input logic             clk,
    input logic             rst,
    input logic [N_IN-1:0]  in_req,
    input logic [N_IN-1:0]  in_ack,
    input logic [N_IN-1:0]  in_eff_req,
    input logic [N_IN-1:0]  in_flush,
    input logic [N_IN-1:0]  drain,
    input logic [N_OUT-1:0] out_req,
    input logic [N_OUT-1:0] out_ack,
    input logic [N_OUT-1:0] fill
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> ((&in_ack) && (out_req == '0)));

    // R5
    retire_chk: assert property (@(posedge clk) disable iff (rst)
        (|(out_req & out_ack & ~fill)) |=> ((out_req & $past(out_req & out_ack & ~fill)) == '0));

    // R6
    fill_chk: assert property (@(posedge clk) disable iff (rst)
        (|fill) |=> ((out_req & $past(fill)) == $past(fill)));

    // R5
    req_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (|out_req) |-> ((out_req & ~$past(out_req) & ~$past(fill)) == '0));

    // R7
    gang_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (&in_flush) |=> (&in_ack));

    // R8
    none_release_chk: assert property (@(posedge clk) disable iff (rst)
        ((in_flush == '0) && (|(~in_req & in_ack & ~drain)))
        |=> ((in_ack & $past(~in_req & in_ack & ~drain)) == '0));

    // R9
    some_consume_chk: assert property (@(posedge clk) disable iff (rst)
        ((in_flush != '0) && !(&in_flush) && (|(in_eff_req & ~in_ack)))
        |=> ((~in_ack & $past(in_eff_req & ~in_ack)) == '0));

    // R10
    drain_chk: assert property (@(posedge clk) disable iff (rst)
        (|drain) |=> ((in_ack & $past(drain)) == $past(drain)));

endmodule

bind dock_flush_coord dock_flush_coord_chk #(.N_IN(N_IN), .N_OUT(N_OUT)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_req     (in_req),
    .in_ack     (in_ack),
    .in_eff_req (in_eff_req),
    .in_flush   (in_flush),
    .drain      (drain),
    .out_req    (out_req),
    .out_ack    (out_ack),
    .fill       (fill)
);

// File: tb/test_dock_flush_coord.sv
`timescale 1ns/1ps
module test_dock_flush_coord;
    localparam int NI = 3;
    localparam int NO = 2;
    localparam int W  = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NI-1:0]        in_req = '0, drain = '0;
    logic [NI*(W+1)-1:0]  in_data = '0;
    logic [NO-1:0]        out_ack = '0, fill = '0;
    logic [NI-1:0]        in_ack, in_eff_req, in_flush, in_full, in_empty;
    logic [NI*W-1:0]      in_word;
    logic [NO-1:0]        out_req, out_full, out_empty;

    always #10 clk = ~clk;

    dock_flush_coord #(.N_IN(NI), .N_OUT(NO), .WORD_W(W)) i_dock_flush_coord (
        .clk(clk), .rst(rst), .in_req(in_req), .in_data(in_data), .drain(drain),
        .in_ack(in_ack), .in_word(in_word), .in_eff_req(in_eff_req),
        .in_flush(in_flush), .in_full(in_full), .in_empty(in_empty),
        .out_ack(out_ack), .fill(fill), .out_req(out_req),
        .out_full(out_full), .out_empty(out_empty)
    );

    int vectors = 0;
    int errors  = 0;
    bit armed   = 0;

    // reference state
    bit    m_ack [NI];
    bit    m_req [NO];
    string ack_tag [NI];
    string req_tag [NO];

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic step(input logic [NI-1:0] rq, input logic [NI-1:0] fg, input logic [NI-1:0] dr,
                        input logic [NO-1:0] fl, input logic [NO-1:0] oa, input logic r);
        bit eff [NI];
        bit flg [NI];
        bit n_ack [NI];
        bit n_req [NO];
        logic [W-1:0] wd [NI];
        int nfl;
        @(negedge clk);
        rst = r; in_req = rq; drain = dr; fill = fl; out_ack = oa;
        for (int i = 0; i < NI; i++) begin
            wd[i] = W'($urandom);
            in_data[i*(W+1) +: W+1] = {fg[i], wd[i]};
        end
        #1;
        nfl = 0;
        for (int i = 0; i < NI; i++) begin
            eff[i] = rq[i] && !fg[i];
            flg[i] = rq[i] && fg[i] && !m_ack[i];
            if (flg[i]) nfl++;
        end
        if (armed) begin
            for (int i = 0; i < NI; i++) begin
                chk(ack_tag[i], $sformatf("in_ack[%0d]", i), 32'(in_ack[i]), 32'(m_ack[i]));
                chk("R2", $sformatf("in_eff_req[%0d]", i), 32'(in_eff_req[i]), 32'(eff[i]));
                chk("R2", $sformatf("in_word[%0d]", i), 32'(in_word[i*W +: W]), 32'(wd[i]));
                chk("R3", $sformatf("in_flush[%0d]", i), 32'(in_flush[i]), 32'(flg[i]));
                chk("R4", $sformatf("in_full[%0d]", i), 32'(in_full[i]), 32'(eff[i] && !m_ack[i]));
                chk("R4", $sformatf("in_empty[%0d]", i), 32'(in_empty[i]), 32'(!eff[i] && !m_ack[i]));
            end
            for (int j = 0; j < NO; j++) begin
                chk(req_tag[j], $sformatf("out_req[%0d]", j), 32'(out_req[j]), 32'(m_req[j]));
                chk("R4", $sformatf("out_full[%0d]", j), 32'(out_full[j]), 32'(m_req[j] && !oa[j]));
                chk("R4", $sformatf("out_empty[%0d]", j), 32'(out_empty[j]), 32'(!m_req[j] && !oa[j]));
            end
        end
        // next state of the reference
        for (int i = 0; i < NI; i++) begin
            if (r) begin
                n_ack[i] = 1; ack_tag[i] = "R1";
            end else if (nfl == NI) begin
                n_ack[i] = 1; ack_tag[i] = "R7";
            end else if (nfl == 0) begin
                n_ack[i] = (!rq[i] && m_ack[i]) ? 0 : m_ack[i]; ack_tag[i] = "R8";
            end else begin
                if (!eff[i] && m_ack[i])      n_ack[i] = 0;
                else if (eff[i] && !m_ack[i]) n_ack[i] = 1;
                else                          n_ack[i] = m_ack[i];
                ack_tag[i] = "R9";
            end
            if (!r && dr[i]) begin
                n_ack[i] = 1; ack_tag[i] = "R10";
            end
        end
        for (int j = 0; j < NO; j++) begin
            if (r)          begin n_req[j] = 0; req_tag[j] = "R1"; end
            else if (fl[j]) begin n_req[j] = 1; req_tag[j] = "R6"; end
            else            begin n_req[j] = (m_req[j] && oa[j]) ? 0 : m_req[j]; req_tag[j] = "R5"; end
        end
        @(posedge clk);
        for (int i = 0; i < NI; i++) m_ack[i] = n_ack[i];
        for (int j = 0; j < NO; j++) m_req[j] = n_req[j];
        if (r) armed = 1;
    endtask

    task automatic reset_check();
        @(negedge clk);
        chk("R1", "in_ack after reset", 32'(in_ack), 32'({NI{1'b1}}));
        chk("R1", "out_req after reset", 32'(out_req), 32'(0));
    endtask

    function automatic logic [NI-1:0] rnd(input int pct);
        logic [NI-1:0] v;
        for (int i = 0; i < NI; i++) v[i] = (($urandom % 100) < pct);
        return v;
    endfunction

    function automatic logic [NO-1:0] rndo(input int pct);
        logic [NO-1:0] v;
        for (int j = 0; j < NO; j++) v[j] = (($urandom % 100) < pct);
        return v;
    endfunction

    initial begin
        for (int i = 0; i < NI; i++) begin m_ack[i] = 1; ack_tag[i] = "R1"; end
        for (int j = 0; j < NO; j++) begin m_req[j] = 0; req_tag[j] = "R1"; end
        step('0, '0, '0, '0, '0, 1'b1);
        step('1, '1, '0, '1, '0, 1'b1);
        reset_check();
        // R8: no requests, acks release
        step('0, '0, '0, '0, '0, 1'b0);
        // R7: every input carries a flush token with ack low
        step('1, '1, '0, '0, '0, 1'b0);
        step('1, '1, '0, '0, '0, 1'b0);
        // release, then R9: input 0 flushes, others carry data
        step('0, '0, '0, '0, '0, 1'b0);
        step(3'b111, 3'b001, '0, '0, '0, 1'b0);
        step(3'b111, 3'b001, '0, '0, '0, 1'b0);
        // R10: drain wins over release
        step('0, '0, 3'b010, '0, '0, 1'b0);
        step('0, '0, '0, '0, '0, 1'b0);
        // R6 then R5: fill, hold without ack, retire with ack
        step('0, '0, '0, 2'b11, '0, 1'b0);
        step('0, '0, '0, '0, 2'b00, 1'b0);
        step('0, '0, '0, '0, 2'b01, 1'b0);
        step('0, '0, '0, 2'b10, 2'b10, 1'b0);
        step('0, '0, '0, '0, 2'b11, 1'b0);
        // random phases with varying densities
        for (int ph = 0; ph < 6; ph++) begin
            int rq_p = 30 + ph * 12;
            int fg_p = (ph % 3 == 0) ? 85 : 35;
            for (int c = 0; c < 150; c++)
                step(rnd(rq_p), rnd(fg_p), rnd(8), rndo(25), rndo(50), 1'b0);
            if (ph == 2) begin
                step(rnd(50), rnd(50), rnd(50), rndo(50), rndo(50), 1'b1);
                reset_check();
            end
        end
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog run actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule